// File: doc/BRIEF.md
# Machine Interrupt Control Register Unit

This unit holds the machine-level interrupt state of a single hart: the global enable and its saved copy, the pending, enable and delegation masks, the trap vector base, the saved return address and the trap cause. It accepts register accesses from the pipeline. These are plain reads, full writes, bit-set and bit-clear operations. It also receives a return-from-trap strobe and the address of the instruction currently in flight.

Each cycle the unit forms the set of interrupts that are pending, enabled and not handed down to a lower privilege level. If that set is non-empty and the global enable is on, the unit takes a trap. It picks the highest-numbered eligible source, saves the in-flight address and the cause, turns interrupts off and emits a one-cycle redirect. The redirect goes to the vector base in direct mode, or to the base plus four times the cause number in vectored mode. A return strobe restores the enable and redirects to the saved address. The pending bit is left set by the trap, so the handler must clear it.

Top module: `mirq_csr_unit`

## Requirements
- R1: After reset every register of the unit reads as zero, and `redirect_valid` and `csr_rdata` are zero.
- R2: `csr_op` encodes 0 as read, 1 as write, 2 as set and 3 as clear. A write replaces the writable bits. A set ORs the data into them. A clear removes the bits that are one in the data. Bits that are not addressed keep their value.
- R3: With `csr_valid` high, `csr_rdata` one cycle later holds the value of the addressed register after that cycle's update, including any hardware update in the same cycle. Register addresses: status 0x300, delegation 0x303, enable 0x304, vector base 0x305, return address 0x341, cause 0x342, pending 0x344. Any other address reads zero and ignores writes.
- R4: Writable bits are limited. In the status register only bit 3 (global enable) and bit 7 (saved enable) can be written. The pending and enable masks accept bits 1, 3, 5, 7, 9 and 11. The delegation mask accepts bits 1, 5 and 9. The return address always has its low two bits at zero.
- R5: A source is taken only when its pending bit, its enable bit and the global enable are all one. The decision uses registered state, so a write that sets the global enable causes the trap on the following cycle.
- R6: A source whose delegation bit is one is never taken. Clearing that bit while the source is pending and enabled lets the trap happen.
- R7: When several sources are eligible, the one with the highest bit number is taken.
- R8: Taking a trap copies the global enable into the saved enable and clears the global enable. It stores `cur_pc` with its low two bits cleared as the return address. It writes the cause as bit 31 set plus the source number. `redirect_valid` is high for exactly the next cycle.
- R9: The redirect target uses the vector base with its low two bits cleared. When bit 0 of the vector base is zero (direct mode) the target is that base. When bit 0 is one (vectored mode) the target is the base plus four times the source number. For example, a base of 0x80000301 and source 1 give 0x80000304.
- R10: Taking a trap leaves the pending mask unchanged.
- R11: A return strobe copies the saved enable into the global enable, sets the saved enable to one and redirects to the return address on the next cycle. A register access in the same cycle is discarded.
- R12: When a trap is taken in the same cycle as a return strobe or a register write, the trap wins and the strobe or write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Register access request |
| csr_op | input | 2 | Access kind: read, write, set, clear |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data, set or clear mask |
| csr_rdata | output | XLEN | Registered read data |
| mret_valid | input | 1 | Return-from-trap strobe |
| cur_pc | input | XLEN | Address of the instruction in flight |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect target |

## Verification
A seeded random stream of reads, writes, sets and clears is applied to every register except the status register, plus one unmapped address. This separates the three merge rules and the per-register writable masks from each other. Directed trap runs cover several cases: a single pending source in vectored mode, several sources at once in direct mode (to show priority), and a delegated source that fires once its delegation is removed. Together they tell a wrong priority, a wrong vector offset and a missing enable or delegation gate apart. Further directed runs put a trap against a same-cycle register write and a return strobe against a same-cycle write, and check that a pending bit survives its own trap.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  typedef enum logic [1:0] {
    CSR_READ  = 2'b00,
    CSR_WRITE = 2'b01,
    CSR_SET   = 2'b10,
    CSR_CLEAR = 2'b11
  } csr_op_e;

  localparam logic [11:0] ADDR_STATUS = 12'h300;
  localparam logic [11:0] ADDR_DELEG  = 12'h303;
  localparam logic [11:0] ADDR_ENABLE = 12'h304;
  localparam logic [11:0] ADDR_TVEC   = 12'h305;
  localparam logic [11:0] ADDR_EPC    = 12'h341;
  localparam logic [11:0] ADDR_CAUSE  = 12'h342;
  localparam logic [11:0] ADDR_PEND   = 12'h344;
endpackage

// File: rtl/mirq_irq_select.sv
module mirq_irq_select #(
  parameter int NIRQ = 12,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] elig,
  output logic            hit,
  output logic [CW-1:0]   idx
);
  // Highest-numbered eligible source wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = CW'(i);
      end
    end
  end

  assert_prio_highest_R7: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((elig >> idx) == NIRQ'(1)));
  assert_none_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (elig == '0));
endmodule

// File: rtl/mirq_trap_target.sv
module mirq_trap_target #(
  parameter int XLEN   = 32,
  parameter int CW     = 4,
  parameter bit VEC_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] tvec,
  input  logic [CW-1:0]   cause,
  output logic [XLEN-1:0] target
);
  localparam int PADW = XLEN - CW - 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec[XLEN-1:2], 2'b00};
  assign offset = {{PADW{1'b0}}, cause, 2'b00};

  generate
    if (VEC_EN) begin : g_vectored
      assign target = tvec[0] ? (base + offset) : base;
    end else begin : g_direct_only
      assign target = base;
    end
  endgenerate

  assert_target_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    target[1:0] == 2'b00);
endmodule

// File: rtl/mirq_csr_unit.sv
module mirq_csr_unit
  import mirq_pkg::*;
#(
  parameter int             XLEN        = 32,
  parameter int             NIRQ        = 12,
  parameter logic [NIRQ-1:0] IRQ_WMASK   = 12'hAAA,
  parameter logic [NIRQ-1:0] DELEG_WMASK = 12'h222,
  parameter bit             VEC_EN      = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_valid,
  input  logic [1:0]      csr_op,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            mret_valid,
  input  logic [XLEN-1:0] cur_pc,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int              CW        = $clog2(NIRQ);
  localparam logic [XLEN-1:0] STAT_MASK = XLEN'(8'h88);
  localparam logic [XLEN-1:0] EPC_MASK  = ~XLEN'(3);

  // State
  logic            gie_q, gie_save_q;
  logic [NIRQ-1:0] pend_q, en_q, deleg_q;
  logic [XLEN-1:0] tvec_q, epc_q, cause_q;

  // Next state
  logic            gie_n, gie_save_n;
  logic [NIRQ-1:0] pend_n, en_n, deleg_n;
  logic [XLEN-1:0] tvec_n, epc_n, cause_n, rdata_n;
  logic [XLEN-1:0] merged;

  logic [NIRQ-1:0] elig;
  logic            hit, take, do_mret, wr_en;
  logic [CW-1:0]   sel;
  logic [XLEN-1:0] tgt, stat_view;
  csr_op_e         op;

  function automatic logic [XLEN-1:0] merge(input csr_op_e o, input logic [XLEN-1:0] old,
                                            input logic [XLEN-1:0] wd, input logic [XLEN-1:0] msk);
    case (o)
      CSR_WRITE: return (old & ~msk) | (wd & msk);
      CSR_SET:   return old | (wd & msk);
      CSR_CLEAR: return old & ~(wd & msk);
      default:   return old;
    endcase
  endfunction

  assign op        = csr_op_e'(csr_op);
  assign elig      = pend_q & en_q & ~deleg_q;
  assign take      = hit & gie_q;
  assign do_mret   = mret_valid & ~take;
  assign wr_en     = csr_valid & ~take & ~mret_valid & (op != CSR_READ);
  assign stat_view = XLEN'({gie_save_q, 3'b000, gie_q, 3'b000});

  mirq_irq_select #(.NIRQ(NIRQ), .CW(CW)) u_select (
    .clk(clk), .rst(rst), .elig(elig), .hit(hit), .idx(sel)
  );

  mirq_trap_target #(.XLEN(XLEN), .CW(CW), .VEC_EN(VEC_EN)) u_target (
    .clk(clk), .rst(rst), .tvec(tvec_q), .cause(sel), .target(tgt)
  );

  always_comb begin
    gie_n      = gie_q;
    gie_save_n = gie_save_q;
    pend_n     = pend_q;
    en_n       = en_q;
    deleg_n    = deleg_q;
    tvec_n     = tvec_q;
    epc_n      = epc_q;
    cause_n    = cause_q;
    merged     = '0;
    if (wr_en) begin
      case (csr_addr)
        ADDR_STATUS: begin
          merged     = merge(op, stat_view, csr_wdata, STAT_MASK);
          gie_n      = merged[3];
          gie_save_n = merged[7];
        end
        ADDR_PEND: begin
          merged = merge(op, XLEN'(pend_q), csr_wdata, XLEN'(IRQ_WMASK));
          pend_n = merged[NIRQ-1:0];
        end
        ADDR_ENABLE: begin
          merged = merge(op, XLEN'(en_q), csr_wdata, XLEN'(IRQ_WMASK));
          en_n   = merged[NIRQ-1:0];
        end
        ADDR_DELEG: begin
          merged  = merge(op, XLEN'(deleg_q), csr_wdata, XLEN'(DELEG_WMASK));
          deleg_n = merged[NIRQ-1:0];
        end
        ADDR_TVEC:  tvec_n  = merge(op, tvec_q, csr_wdata, '1);
        ADDR_EPC:   epc_n   = merge(op, epc_q, csr_wdata, EPC_MASK);
        ADDR_CAUSE: cause_n = merge(op, cause_q, csr_wdata, '1);
        default: ;
      endcase
    end
    if (take) begin
      gie_save_n = gie_q;
      gie_n      = 1'b0;
      epc_n      = {cur_pc[XLEN-1:2], 2'b00};
      cause_n    = {1'b1, (XLEN-1)'(sel)};
    end else if (do_mret) begin
      gie_n      = gie_save_q;
      gie_save_n = 1'b1;
    end
  end

  // Read returns the post-update value of the addressed register.
  always_comb begin
    case (csr_addr)
      ADDR_STATUS: rdata_n = XLEN'({gie_save_n, 3'b000, gie_n, 3'b000});
      ADDR_PEND:   rdata_n = XLEN'(pend_n);
      ADDR_ENABLE: rdata_n = XLEN'(en_n);
      ADDR_DELEG:  rdata_n = XLEN'(deleg_n);
      ADDR_TVEC:   rdata_n = tvec_n;
      ADDR_EPC:    rdata_n = epc_n;
      ADDR_CAUSE:  rdata_n = cause_n;
      default:     rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q          <= 1'b0;
      gie_save_q     <= 1'b0;
      pend_q         <= '0;
      en_q           <= '0;
      deleg_q        <= '0;
      tvec_q         <= '0;
      epc_q          <= '0;
      cause_q        <= '0;
      csr_rdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      gie_q          <= gie_n;
      gie_save_q     <= gie_save_n;
      pend_q         <= pend_n;
      en_q           <= en_n;
      deleg_q        <= deleg_n;
      tvec_q         <= tvec_n;
      epc_q          <= epc_n;
      cause_q        <= cause_n;
      if (csr_valid) csr_rdata <= rdata_n;
      redirect_valid <= take | do_mret;
      redirect_pc    <= take ? tgt : epc_q;
    end
  end

  assert_trap_disables_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> (redirect_valid && !gie_q && gie_save_q));
  assert_epc_capture_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc_q == {$past(cur_pc[XLEN-1:2]), 2'b00}));
  assert_deleg_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> !deleg_q[sel]);
  assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    take |=> (pend_q == $past(pend_q)));
  assert_mret_restore_R11: assert property (@(posedge clk) disable iff (rst)
    (mret_valid && !take) |=> (gie_save_q && (gie_q == $past(gie_save_q)) && redirect_valid));
  assert_trap_beats_write_R12: assert property (@(posedge clk) disable iff (rst)
    (take && csr_valid) |=> (cause_q[XLEN-1] && (epc_q[1:0] == 2'b00)));
endmodule

// File: tb/tb_mirq_csr_unit.sv
module tb_mirq_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  localparam logic [11:0] A_ST = 12'h300, A_DL = 12'h303, A_IE = 12'h304, A_TV = 12'h305,
                          A_EP = 12'h341, A_CA = 12'h342, A_IP = 12'h344, A_NONE = 12'h7C0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_valid = 1'b0;
  logic [1:0] csr_op = 2'd0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic mret_valid = 1'b0;
  logic [XLEN-1:0] cur_pc = '0;
  logic redirect_valid;
  logic [XLEN-1:0] redirect_pc;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  logic [XLEN-1:0] rd_log [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  mirq_csr_unit dut (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mret_valid(mret_valid), .cur_pc(cur_pc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always @(negedge clk) begin
    if (!rst && redirect_valid) begin
      if (rd_cnt < 16) rd_log[rd_cnt] = redirect_pc;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; csr_valid = 1'b0; mret_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic csr(input logic [1:0] op, input logic [11:0] addr, input logic [XLEN-1:0] wd,
                     output logic [XLEN-1:0] rd);
    @(negedge clk);
    csr_valid = 1'b1; csr_op = op; csr_addr = addr; csr_wdata = wd;
    @(negedge clk);
    rd = csr_rdata;
    csr_valid = 1'b0;
  endtask

  task automatic mret_pulse();
    @(negedge clk);
    mret_valid = 1'b1;
    @(negedge clk);
    mret_valid = 1'b0;
  endtask

  function automatic logic [XLEN-1:0] upd(input logic [1:0] op, input logic [XLEN-1:0] old,
                                          input logic [XLEN-1:0] wd, input logic [XLEN-1:0] msk);
    logic [XLEN-1:0] r;
    r = old;
    if (op == 2'd1) r = (old & ~msk) | (wd & msk);
    else if (op == 2'd2) r = old | (wd & msk);
    else if (op == 2'd3) r = old & ~(wd & msk);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] r;
    logic [XLEN-1:0] m_ie, m_ip, m_dl, m_tv, m_ep, m_ca, exp_v, wd;
    logic [11:0] addrs [0:6];
    int base;
    void'($urandom(32'd20240117));
    addrs[0] = A_IE; addrs[1] = A_IP; addrs[2] = A_DL; addrs[3] = A_TV;
    addrs[4] = A_EP; addrs[5] = A_CA; addrs[6] = A_NONE;

    // R1: reset state
    do_reset();
    settle(1);
    check("R1 redirect_valid", XLEN'(redirect_valid), '0);
    check("R1 csr_rdata", csr_rdata, '0);
    csr(2'd0, A_ST, '0, r); check("R1 status", r, '0);
    for (int i = 0; i < 6; i++) begin
      csr(2'd0, addrs[i], '0, r); check("R1 register", r, '0);
    end

    // R2/R3/R4: seeded random access stream, status untouched so no trap
    m_ie = '0; m_ip = '0; m_dl = '0; m_tv = '0; m_ep = '0; m_ca = '0;
    for (int n = 0; n < 300; n++) begin
      int k;
      logic [1:0] op;
      k  = $urandom_range(0, 6);
      op = 2'($urandom_range(0, 3));
      wd = ($urandom_range(0, 1) == 1) ? XLEN'($urandom_range(0, 31)) : XLEN'($urandom);
      case (k)
        0: begin m_ie = upd(op, m_ie, wd, 32'hAAA); exp_v = m_ie; end
        1: begin m_ip = upd(op, m_ip, wd, 32'hAAA); exp_v = m_ip; end
        2: begin m_dl = upd(op, m_dl, wd, 32'h222); exp_v = m_dl; end
        3: begin m_tv = upd(op, m_tv, wd, 32'hFFFF_FFFF); exp_v = m_tv; end
        4: begin m_ep = upd(op, m_ep, wd, 32'hFFFF_FFFC); exp_v = m_ep; end
        5: begin m_ca = upd(op, m_ca, wd, 32'hFFFF_FFFF); exp_v = m_ca; end
        default: exp_v = '0;
      endcase
      csr(op, addrs[k], wd, r);
      check("R2 R3 R4 random access", r, exp_v);
    end

    // R4: writable masks of status, delegation, pending
    do_reset();
    csr(2'd1, A_ST, 32'hFFFF_FFFF, r); check("R4 status mask", r, 32'h88);
    csr(2'd1, A_DL, 32'hFFFF_FFFF, r); check("R4 deleg mask", r, 32'h222);
    csr(2'd1, A_IP, 32'hFFFF_FFFF, r); check("R4 pending mask", r, 32'hAAA);
    csr(2'd1, A_EP, 32'h1234_5677, r); check("R4 epc align", r, 32'h1234_5674);

    // R5/R8/R9/R10: vectored trap for source 1
    do_reset();
    cur_pc = 32'h8000_01E0;
    csr(2'd1, A_TV, 32'h8000_0301, r);
    csr(2'd1, A_IP, 32'h2, r);
    csr(2'd1, A_IE, 32'h2, r);
    base = rd_cnt;
    settle(3);
    check("R5 no trap without global enable", XLEN'(rd_cnt - base), '0);
    csr(2'd2, A_ST, 32'h8, r);
    check("R3 status read before trap", r, 32'h8);
    settle(2);
    check("R5 trap count", XLEN'(rd_cnt - base), 32'd1);
    check("R9 vectored target", rd_log[base], 32'h8000_0304);
    csr(2'd0, A_CA, '0, r); check("R8 cause", r, 32'h8000_0001);
    csr(2'd0, A_EP, '0, r); check("R8 epc", r, 32'h8000_01E0);
    csr(2'd0, A_ST, '0, r); check("R8 status after trap", r, 32'h80);
    csr(2'd0, A_IP, '0, r); check("R10 pending kept", r, 32'h2);

    // R11: return strobe with a same-cycle write that must be dropped
    csr(2'd3, A_IP, 32'h2, r);
    base = rd_cnt;
    @(negedge clk);
    mret_valid = 1'b1; csr_valid = 1'b1; csr_op = 2'd1; csr_addr = A_EP; csr_wdata = 32'h999;
    @(negedge clk);
    mret_valid = 1'b0; csr_valid = 1'b0;
    settle(2);
    check("R11 return count", XLEN'(rd_cnt - base), 32'd1);
    check("R11 return target", rd_log[base], 32'h8000_01E0);
    csr(2'd0, A_ST, '0, r); check("R11 status after return", r, 32'h88);
    csr(2'd0, A_EP, '0, r); check("R11 write dropped", r, 32'h8000_01E0);

    // R6: delegated source held off, then taken once delegation is removed
    csr(2'd1, A_DL, 32'h2, r);
    csr(2'd2, A_IP, 32'h2, r);
    base = rd_cnt;
    settle(3);
    check("R6 delegated not taken", XLEN'(rd_cnt - base), '0);
    csr(2'd3, A_DL, 32'h2, r);
    settle(2);
    check("R6 taken after undelegate", XLEN'(rd_cnt - base), 32'd1);
    check("R6 target", rd_log[base], 32'h8000_0304);

    // R7/R9: priority in direct mode, then vectored after return
    do_reset();
    cur_pc = 32'h0000_0040;
    csr(2'd1, A_TV, 32'h0000_1000, r);
    csr(2'd1, A_IE, 32'hFFF, r);
    csr(2'd1, A_IP, 32'h888, r);
    base = rd_cnt;
    csr(2'd2, A_ST, 32'h8, r);
    settle(2);
    check("R9 direct target", rd_log[base], 32'h1000);
    csr(2'd0, A_CA, '0, r); check("R7 highest source", r, 32'h8000_000B);
    csr(2'd3, A_IP, 32'h800, r);
    csr(2'd1, A_TV, 32'h0000_2001, r);
    mret_pulse();
    settle(3);
    check("R7 redirect count", XLEN'(rd_cnt - base), 32'd3);
    check("R11 return to epc", rd_log[base + 1], 32'h40);
    check("R9 vectored source 7", rd_log[base + 2], 32'h201C);
    csr(2'd0, A_CA, '0, r); check("R7 next source", r, 32'h8000_0007);

    // R12: trap in the same cycle as a register write
    do_reset();
    cur_pc = 32'h0000_0400;
    csr(2'd1, A_TV, 32'h0000_0100, r);
    csr(2'd1, A_IP, 32'h2, r);
    csr(2'd1, A_IE, 32'h2, r);
    base = rd_cnt;
    @(negedge clk);
    csr_valid = 1'b1; csr_op = 2'd2; csr_addr = A_ST; csr_wdata = 32'h8;
    @(negedge clk);
    csr_op = 2'd1; csr_addr = A_EP; csr_wdata = 32'h55;
    @(negedge clk);
    csr_valid = 1'b0;
    settle(1);
    check("R12 trap taken", XLEN'(rd_cnt - base), 32'd1);
    check("R12 target", rd_log[base], 32'h100);
    csr(2'd0, A_EP, '0, r); check("R12 write discarded", r, 32'h400);
    csr(2'd0, A_CA, '0, r); check("R12 cause", r, 32'h8000_0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule